// File: doc/BRIEF.md
# Two-Level Micro/Nano Control Store

This block is a writable control store split into two levels. The first level is a deep, narrow table indexed by the control address that an external sequencer drives. Each entry of that table holds only a short pointer. The pointer selects one entry of a second, shallow table. Each entry of the second table is a wide horizontal control word, and each bit of that word drives one control point directly. Many micro addresses can share one stored control word. With the default sizes, the store holds 2048×8 + 256×200 = 67,584 bits. A flat store with one full word per address would need 409,600 bits.

A lookup makes two dependent synchronous reads. On one clock edge the block samples the address and reads the pointer. On the next edge it reads the control word into the output register, and a valid flag travels alongside. A single write port fills either level at run time, so the control program can be changed while the block is in use. The sequencer, the datapath and any field decoding of the control word sit outside this block.

Top module: `ucs_two_level`

## Requirements
- R1: After reset, `ctrl_word` is all zeros and `ctrl_valid` is low, and both stay that way until the first lookup completes.
- R2: If `rd_en` is high at a clock edge, the result of that lookup appears on `ctrl_word` after the following clock edge. It is therefore visible one full cycle after the edge that sampled the address.
- R3: The word a lookup returns is the second-level entry whose index is the pointer stored at first-level entry `rd_addr`.
- R4: `ctrl_valid` is high after an edge exactly when the lookup sampled one edge earlier had `rd_en` high, and low otherwise.
- R5: A write with `wr_en`=1 and `wr_sel`=0 (first level) stores `wr_data[7:0]` at pointer entry `wr_addr`. The remaining bits of `wr_data` are ignored.
- R6: A write with `wr_en`=1 and `wr_sel`=1 (second level) stores all of `wr_data` at control-word entry `wr_addr[7:0]`. Bits `wr_addr[10:8]` are ignored.
- R7: A write and a read of the same entry at the same edge return the old contents. This holds for a pointer write at the edge that samples the address, and for a control-word write at the edge that loads the output.
- R8: When no lookup completes, `ctrl_word` keeps its previous value. Writes to either level never change the output register directly.
- R9: A new lookup may be issued at every edge, and each one returns its own result in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Start a lookup at this edge |
| rd_addr | input | 11 | Control address from the sequencer |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 pointer level, 1 control-word level |
| wr_addr | input | 11 | Write address (low 8 bits for the control-word level) |
| wr_data | input | 200 | Write data (low 8 bits for the pointer level) |
| ctrl_word | output | 200 | Registered horizontal control word |
| ctrl_valid | output | 1 | Marks `ctrl_word` as the result of a completed lookup |

## Verification
The bench aims pointer writes at the address being looked up in the same cycle. A design that forwarded the new pointer would return a different word instead of the old one. It also writes the control word that an in-flight pointer selects, one cycle later. A store with write-first behaviour would show the new word a cycle too early. Other cases cover back-to-back lookups, where a mis-timed valid stage would shift or drop results, and idle gaps, where a broken hold would clear or change the output. Nano writes with high address bits set check that those bits are ignored; a design that used them would write past the second table.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
   localparam int unsigned UCS_ADDR_W = 11;
   localparam int unsigned UCS_PTR_W  = 8;
   localparam int unsigned UCS_WORD_W = 200;

   typedef enum logic {
      UCS_TGT_PTR  = 1'b0,
      UCS_TGT_WORD = 1'b1
   } ucs_target_e;
endpackage

// File: rtl/ucs_ptr_store.sv
// First level: deep table of short pointers, synchronous read.
module ucs_ptr_store #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PTR_W-1:0]  wr_data,
   output logic [PTR_W-1:0]  ptr_q
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [PTR_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= '0;
      else if (rd_en) ptr_q <= mem[rd_addr];
   end
endmodule

// File: rtl/ucs_word_store.sv
// Second level: shallow table of wide control words; its read register is the output.
module ucs_word_store #(
   parameter int unsigned PTR_W     = 8,
   parameter int unsigned WORD_W    = 200,
   parameter bit          HOLD_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  rd_idx,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] word_q
);
   localparam int unsigned DEPTH = 1 << PTR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   generate
      if (HOLD_WORD) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)     word_q <= '0;
            else if (rd_en) word_q <= mem[rd_idx];
         end
      end else begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n)     word_q <= '0;
            else if (rd_en) word_q <= mem[rd_idx];
            else            word_q <= '0;
         end
      end
   endgenerate
endmodule

// File: rtl/ucs_valid_pipe.sv
// Valid flag that tracks each lookup through both read stages.
module ucs_valid_pipe #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic [STAGES-1:0] stage_valid
);
   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_valid[s] <= 1'b0;
               else        stage_valid[s] <= in_valid;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_valid[s] <= 1'b0;
               else        stage_valid[s] <= stage_valid[s-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ucs_two_level.sv
module ucs_two_level #(
   parameter int unsigned ADDR_W    = ucs_pkg::UCS_ADDR_W,
   parameter int unsigned PTR_W     = ucs_pkg::UCS_PTR_W,
   parameter int unsigned WORD_W    = ucs_pkg::UCS_WORD_W,
   parameter bit          HOLD_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] ctrl_word,
   output logic              ctrl_valid
);
   import ucs_pkg::*;

   localparam int unsigned LAT = 2;

   generate
      if (PTR_W < 1 || PTR_W > 16) begin : g_bad_ptr
         $error("ucs_two_level: PTR_W out of range");
      end
      if (ADDR_W < PTR_W) begin : g_bad_addr
         $error("ucs_two_level: ADDR_W must cover the word index");
      end
      if (WORD_W < PTR_W) begin : g_bad_word
         $error("ucs_two_level: WORD_W must carry a pointer");
      end
   endgenerate

   logic             ptr_we, word_we;
   logic [PTR_W-1:0] ptr_q;
   logic [LAT-1:0]   vld;

   assign ptr_we  = wr_en && (ucs_target_e'(wr_sel) == UCS_TGT_PTR);
   assign word_we = wr_en && (ucs_target_e'(wr_sel) == UCS_TGT_WORD);

   ucs_ptr_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .wr_en   (ptr_we),
      .wr_addr (wr_addr),
      .wr_data (wr_data[PTR_W-1:0]),
      .ptr_q   (ptr_q)
   );

   ucs_valid_pipe #(.STAGES(LAT)) u_vld (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (rd_en),
      .stage_valid (vld)
   );

   ucs_word_store #(.PTR_W(PTR_W), .WORD_W(WORD_W), .HOLD_WORD(HOLD_WORD)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (vld[0]),
      .rd_idx  (ptr_q),
      .wr_en   (word_we),
      .wr_idx  (wr_addr[PTR_W-1:0]),
      .wr_data (wr_data),
      .word_q  (ctrl_word)
   );

   assign ctrl_valid = vld[LAT-1];
endmodule

// File: rtl/ucs_chk.sv
module ucs_chk #(
   parameter int unsigned WORD_W    = 200,
   parameter bit          HOLD_WORD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [WORD_W-1:0] ctrl_word,
   input logic              ctrl_valid
);
   a_r1_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (ctrl_word == '0 && !ctrl_valid));

   a_r2_valid_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ##2 ctrl_valid);

   a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> ##2 !ctrl_valid);

   generate
      if (HOLD_WORD) begin : g_hold_chk
         a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_valid |-> $stable(ctrl_word));
      end
   endgenerate
endmodule

bind ucs_two_level ucs_chk #(.WORD_W(WORD_W), .HOLD_WORD(HOLD_WORD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .ctrl_word  (ctrl_word),
   .ctrl_valid (ctrl_valid)
);

// File: tb/tb_ucs_two_level.sv
module tb_ucs_two_level;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW = 11;
   localparam int unsigned PW = 8;
   localparam int unsigned WW = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [WW-1:0] wr_data = '0;
   logic [WW-1:0] ctrl_word;
   logic          ctrl_valid;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // behavioural model
   logic [PW-1:0] m_ptr [1 << AW];
   logic [WW-1:0] m_word [1 << PW];
   logic          m_v1 = 1'b0, m_v2 = 1'b0;
   logic [PW-1:0] m_p1 = '0;
   logic [WW-1:0] m_w2 = '0;

   ucs_two_level dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [WW-1:0] rand_word();
      logic [WW-1:0] w = '0;
      for (int i = 0; i < 7; i++) w = (w << 32) | WW'($urandom);
      return w;
   endfunction

   task automatic check(input string req);
      n_run++;
      if (ctrl_valid !== m_v2 || ctrl_word !== m_w2) begin
         n_fail++;
         $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                  req, ctrl_valid, ctrl_word, m_v2, m_w2);
      end
   endtask

   // one cycle: drive at negedge, advance model through the edge, check at next negedge
   task automatic cyc(input logic re, input logic [AW-1:0] ra,
                      input logic we, input logic ws, input logic [AW-1:0] wa,
                      input logic [WW-1:0] wd, input string req);
      rd_en = re; rd_addr = ra; wr_en = we; wr_sel = ws; wr_addr = wa; wr_data = wd;
      // model of the edge: reads see contents before this edge's write (R7)
      if (m_v1) m_w2 = m_word[m_p1];
      m_v2 = m_v1;
      m_v1 = re;
      if (re) m_p1 = m_ptr[ra];
      if (we && !ws) m_ptr[wa] = wd[PW-1:0];        // R5
      if (we && ws)  m_word[wa[PW-1:0]] = wd;       // R6
      @(posedge clk);
      @(negedge clk);
      check(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      n_run++;                                         // R1 in reset
      if (ctrl_word !== '0 || ctrl_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: valid=%0b word=%h expected valid=0 word=0", ctrl_valid, ctrl_word);
      end
      rst_n = 1'b1;
      // fill both levels; R1: output stays clear through writes
      for (int i = 0; i < (1 << PW); i++)
         cyc(1'b0, '0, 1'b1, 1'b1, AW'(i), rand_word(), "R1");
      for (int i = 0; i < (1 << AW); i++)
         cyc(1'b0, '0, 1'b1, 1'b0, AW'(i), rand_word(), "R5");
      // R2/R3: single lookup then idle
      cyc(1'b1, 11'd5, 1'b0, 1'b0, '0, '0, "R2");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R3");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R8");
      // R8: writes during idle do not touch the output
      cyc(1'b0, '0, 1'b1, 1'b1, AW'(m_ptr[5]), rand_word(), "R8");
      cyc(1'b0, '0, 1'b1, 1'b0, 11'd5, rand_word(), "R8");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R8");
      // R7: pointer write at the same edge as the read of that entry
      cyc(1'b1, 11'd77, 1'b1, 1'b0, 11'd77, WW'(8'hA5), "R7");
      // R7: word write at the edge that loads the output from that entry
      cyc(1'b0, '0, 1'b1, 1'b1, AW'(m_p1), rand_word(), "R7");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R7");
      cyc(1'b1, 11'd77, 1'b0, 1'b0, '0, '0, "R7");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R7");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R7");
      // R6: high address bits ignored on a word write
      cyc(1'b0, '0, 1'b1, 1'b1, 11'h7C3, rand_word(), "R6");
      cyc(1'b0, '0, 1'b1, 1'b0, 11'd9, WW'(8'hC3), "R6");
      cyc(1'b1, 11'd9, 1'b0, 1'b0, '0, '0, "R6");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R6");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R6");
      // R9: back-to-back lookups
      for (int i = 0; i < 40; i++)
         cyc(1'b1, AW'(i * 37), 1'b0, 1'b0, '0, '0, "R9");
      // random mix, biased towards collisions on a small address set
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] ra, wa;
         logic sel;
         ra  = ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom);
         sel = 1'($urandom);
         wa  = ($urandom % 3 == 0) ? (sel ? AW'(m_p1) | AW'($urandom % 8 << PW) : ra)
                                   : AW'($urandom);
         cyc(1'($urandom % 4 != 0), ra, 1'($urandom % 3 == 0), sel, wa, rand_word(), "R4");
      end
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R4");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R4");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule